// File: doc/BRIEF.md
# Serial Memory Page Write Buffer Controller

This block sits behind the byte-level front end of a serial memory device. It collects one write burst in a 16-byte staging buffer and then copies that buffer into the backing byte array in a single timed internal write cycle. The front end first hands it a start address, then a stream of data bytes, each with a one-cycle strobe. The burst ends with either a STOP indication or an abort. An abort covers a repeated START and any other early termination.

Only the low four address bits advance while bytes arrive, so a burst never leaves its page. Bytes past the sixteenth wrap around to the start of the page and replace bytes that arrived earlier. A per-slot valid mask records which slots were loaded. When STOP arrives, the array receives only those slots, all in one write cycle. The block then stays busy for a parameterised number of clocks and ignores the bus while it is busy.

The array is held inside the block and is erased to 0xFF by reset. A plain combinational read port lets the surrounding read path, or a bench, see the array contents.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, `busy` is 0, `ready` is 1 and `wr_en` is 0.
- R2: A pulse on `addr_load` starts a new burst. `start_addr[3:0]` becomes the in-page offset, and the upper address bits become the page. The first data byte is stored at that offset.
- R3: Each accepted byte advances only the 4-bit offset, which wraps from 15 to 0. The page bits stay fixed for the whole burst.
- R4: If more than 16 bytes arrive before STOP, the later bytes overwrite the slots loaded earlier in the same burst. The last byte for each slot is the one committed.
- R5: The array changes only in the cycle in which STOP is accepted with at least one loaded slot. Before that, the buffered bytes are invisible at the read port.
- R6: The commit writes, in one cycle, exactly the slots loaded in the burst, as given by `wr_mask` bit i for offset i. Bytes of the page that were not loaded keep their old values.
- R7: Once STOP is accepted, `busy` goes high at the next clock and stays high for exactly `WR_CYC` cycles. `ready` is the inverse of `busy`.
- R8: A burst of a single data byte followed by STOP writes that one byte through the same path.
- R9: An abort discards the buffered bytes and the mask. A STOP that follows it then writes nothing and starts no busy interval.
- R10: While `busy` is high, `addr_load`, `byte_vld`, `stop` and `abort` are ignored.
- R11: A STOP with no byte loaded since the last commit, abort or address load writes nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | ADDR_W | Burst start address |
| addr_load | input | 1 | Start a new burst at `start_addr` |
| byte_data | input | 8 | Data byte |
| byte_vld | input | 1 | Strobe: `byte_data` is valid this cycle |
| stop | input | 1 | Burst ended with STOP: commit the buffer |
| abort | input | 1 | Burst ended with repeated START or abort: discard the buffer |
| busy | output | 1 | Internal write cycle in progress |
| ready | output | 1 | Block accepts new bursts |
| wr_en | output | 1 | Array write strobe (commit cycle) |
| wr_page | output | ADDR_W-4 | Page being written |
| wr_data | output | 128 | Buffer contents, byte i at bits 8i+7:8i |
| wr_mask | output | 16 | Loaded-slot mask, bit i for offset i |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |

## Verification
Some rules are checked on every cycle by the assertions:
- the offset advances by exactly one per accepted byte while the page holds;
- an abort empties the mask;
- no commit happens while busy, and every commit is followed by a busy interval of exactly `WR_CYC` cycles;
- the burst state is frozen while busy;
- an empty STOP starts no busy interval.

Other properties can only be shown by the bench's scenarios, which compare the whole array against a reference image after every burst:
- the data actually lands at the wrapped addresses;
- later bytes win over earlier ones in an overlong burst;
- unloaded bytes of the page survive;
- the erased state after reset holds.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int OFS_W      = $clog2(PAGE_BYTES);
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      addr_load,
  input  logic [ADDR_W-1:0]         start_addr,
  input  logic                      byte_vld,
  input  byte_t                     byte_data,
  input  logic                      abort,
  input  logic                      commit,
  output logic [PG_W-1:0]           page_o,
  output logic [OFS_W-1:0]          ofs_o,
  output logic [PAGE_BYTES*8-1:0]   buf_o,
  output logic [PAGE_BYTES-1:0]     mask_o
);
  byte_t                 buf_q [PAGE_BYTES];
  byte_t                 buf_d [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [OFS_W-1:0]      ofs_q, ofs_d;
  logic [PG_W-1:0]       page_q, page_d;

  always_comb begin
    buf_d  = buf_q;
    mask_d = mask_q;
    ofs_d  = ofs_q;
    page_d = page_q;
    if (en) begin
      if (abort || commit) begin
        mask_d = '0;
      end else if (addr_load) begin
        page_d = start_addr[ADDR_W-1:OFS_W];
        ofs_d  = start_addr[OFS_W-1:0];
        mask_d = '0;
      end else if (byte_vld) begin
        buf_d[ofs_q]  = byte_data;
        mask_d[ofs_q] = 1'b1;
        ofs_d         = ofs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ofs_q  <= '0;
      page_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= '0;
    end else if (en) begin
      mask_q <= mask_d;
      ofs_q  <= ofs_d;
      page_q <= page_d;
      buf_q  <= buf_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign buf_o[g*8 +: 8] = buf_q[g];
  end

  assign page_o = page_q;
  assign ofs_o  = ofs_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int WR_CYC = 625000,
  localparam int CNT_W = (WR_CYC > 2) ? $clog2(WR_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WR_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start || busy_q) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PG_W   = ADDR_W - OFS_W,
  localparam int PAGES  = DEPTH / PAGE_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PG_W-1:0]         wr_page,
  input  logic [PAGE_BYTES*8-1:0] wr_data,
  input  logic [PAGE_BYTES-1:0]   wr_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output byte_t                   rd_data
);
  byte_t cells [DEPTH];

  for (genvar p = 0; p < PAGES; p++) begin : g_pg
    logic hit;
    assign hit = wr_en && (wr_page == PG_W'(p));
    for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_ln
      byte_t cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cell_q <= 8'hFF;
        else if (hit && wr_mask[l]) cell_q <= wr_data[l*8 +: 8];
      end
      assign cells[p*PAGE_BYTES + l] = cell_q;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WR_CYC = 625000,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic                    addr_load,
  input  logic [7:0]              byte_data,
  input  logic                    byte_vld,
  input  logic                    stop,
  input  logic                    abort,
  output logic                    busy,
  output logic                    ready,
  output logic                    wr_en,
  output logic [PG_W-1:0]         wr_page,
  output logic [PAGE_BYTES*8-1:0] wr_data,
  output logic [PAGE_BYTES-1:0]   wr_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  logic             idle;
  logic             commit;
  logic [OFS_W-1:0] cur_ofs;
  logic [PG_W-1:0]  cur_page;

  assign idle   = !busy;
  assign commit = idle && stop && !abort && (|wr_mask);

  pgbuf_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .en(idle),
    .addr_load(addr_load), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .abort(abort), .commit(commit),
    .page_o(cur_page), .ofs_o(cur_ofs),
    .buf_o(wr_data), .mask_o(wr_mask)
  );

  pgbuf_timer #(.WR_CYC(WR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
  );

  pgbuf_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_page(cur_page),
    .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign wr_en   = commit;
  assign wr_page = cur_page;
  assign ready   = idle;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int ADDR_W = 8,
  parameter int WR_CYC = 625000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                wr_en,
  input logic                byte_vld,
  input logic                abort,
  input logic                addr_load,
  input logic                stop,
  input logic [3:0]          ofs,
  input logic [ADDR_W-5:0]   page,
  input logic [15:0]         mask
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(WR_CYC)));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  // R5
  no_busy_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

  // R3
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !busy && !abort && !stop && !addr_load)
      |=> (ofs == $past(ofs) + 4'd1) && $stable(page));

  // R9
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !busy) |=> (mask == '0));

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ofs) && $stable(page) && $stable(mask));

  // R11
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && (mask == '0)) |=> !busy);
endmodule

bind pgbuf_ctrl pgbuf_chk #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en),
  .byte_vld(byte_vld), .abort(abort), .addr_load(addr_load), .stop(stop),
  .ofs(cur_ofs), .page(cur_page), .mask(wr_mask)
);

// File: tb/pgbuf_ctrl_test.sv
`timescale 1ns/1ps
module pgbuf_ctrl_test;
  localparam int ADDR_W = 8;
  localparam int WR_CYC = 20;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 6;
  // {start address, byte count, first data value}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'd1,  8'h11},
    {8'h25, 8'd4,  8'h40},
    {8'h3A, 8'd20, 8'h80},
    {8'hF0, 8'd16, 8'hC0},
    {8'h77, 8'd16, 8'hA0},
    {8'h12, 8'd2,  8'hE0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] start_addr;
  logic              addr_load, byte_vld, stop, abort;
  logic [7:0]        byte_data;
  logic              busy, ready, wr_en;
  logic [ADDR_W-5:0] wr_page;
  logic [127:0]      wr_data;
  logic [15:0]       wr_mask;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pgbuf_ctrl #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .addr_load(addr_load),
    .byte_data(byte_data), .byte_vld(byte_vld), .stop(stop), .abort(abort),
    .busy(busy), .ready(ready), .wr_en(wr_en), .wr_page(wr_page),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = ADDR_W'(i);
      #0.01;
      if (rd_data !== model[i]) begin
        if (bad == 0) $display("  first mismatch at %0h: %0h vs %0h", i, rd_data, model[i]);
        bad++;
      end
    end
    check(req, bad, 0);
    @(negedge clk);
  endtask

  task automatic load_addr(input logic [7:0] a);
    start_addr = a; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d);
    byte_data = d; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
  endtask
  task automatic send_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic send_abort();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 10*WR_CYC) begin n++; @(negedge clk); end
  endtask
  task automatic model_burst(input logic [7:0] a, input int cnt, input logic [7:0] seed);
    logic [3:0] o = a[3:0];
    for (int i = 0; i < cnt; i++) begin
      model[{a[7:4], o}] = seed + 8'(i);
      o = o + 4'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired (run hung)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; addr_load = 0; byte_vld = 0; stop = 0; abort = 0;
    start_addr = '0; byte_data = '0; rd_addr = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 wr_en", int'(wr_en), 0);
    compare_mem("R1 erased array");

    // Table walk: R2 R3 R4 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, seed;
      int cnt;
      a = VEC[v][23:16]; cnt = int'(VEC[v][15:8]); seed = VEC[v][7:0];
      load_addr(a);
      for (int i = 0; i < cnt; i++) send_byte(seed + 8'(i));
      compare_mem("R5 array unchanged before STOP");
      send_stop();
      check("R7 ready low while busy", int'(ready), 0);
      busy_len(n);
      check("R7 busy length", n, WR_CYC);
      model_burst(a, cnt, seed);
      if (cnt == 1)      compare_mem("R8 single byte write");
      else if (cnt > 16) compare_mem("R4 R3 overlong burst wraps in page");
      else               compare_mem("R2 R6 page burst commit");
    end

    // R9 abort discards
    load_addr(8'h50);
    send_byte(8'h5A); send_byte(8'h5B);
    send_abort();
    send_stop();
    check("R9 no busy after abort+STOP", int'(busy), 0);
    compare_mem("R9 array unchanged after abort");

    // R10 inputs ignored while busy
    load_addr(8'h60);
    send_byte(8'h01);
    send_stop();
    model[8'h60] = 8'h01;
    load_addr(8'h90);
    send_byte(8'h99); send_byte(8'h9A);
    send_stop();
    busy_len(n);
    check("R10 busy length unaffected", n + 4, WR_CYC);
    send_stop();
    check("R10 bytes during busy not buffered", int'(busy), 0);
    compare_mem("R10 array after busy-time stimulus");

    // R11 STOP right after address load
    load_addr(8'h80);
    send_stop();
    check("R11 no busy on empty STOP", int'(busy), 0);
    check("R11 no write strobe", int'(wr_en), 0);
    compare_mem("R11 array unchanged");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule